// File: doc/BRIEF.md
# Coprocessor Host Register Interface

This block is the register interface that a host processor uses to drive a graphics or maths coprocessor over an 8-bit bus. The host presents an address, a data byte and one-cycle read or write strobes. Only the low ten address bits matter. The block splits that 10-bit offset into regions. Offsets 0x000–0x01F hold sixteen 16-bit general registers, which the host reaches one byte at a time. Offsets 0x030–0x03F hold status, configuration and bank registers. Offsets 0x100–0x2FF form a window that is forwarded to an external code-cache port. Every other offset reads as zero.

Several host accesses have side effects, and this block owns them. Writing the top byte of the last general register starts the core. Reading the status high byte clears the interrupt flag. A host write that stops the core clears the cache base and requests a cache flush. Writing the program bank also requests a flush. Any write to general register 14 requests a ROM-buffer prefetch. The cache storage and the core itself sit outside this block. The core reaches the general registers through a separate read port. It raises the interrupt and loads the cache base through dedicated inputs.

Top module: `cpx_host_regs`

## Requirements
- R1: Only host_addr[9:0] is decoded. Two accesses whose addresses differ only above bit 9 behave identically.
- R2: A strobe at an offset from 0x100 to 0x2FF drives cache_rd or cache_wr in the same cycle, with cache_idx = offset − 0x100 and cache_wdata = host_wdata. A read returns cache_rdata. No other offset drives the cache strobes.
- R3: Offsets 0x000–0x01F address general register offset[4:1]. Offset bit 0 = 0 selects bits 7:0 and 1 selects bits 15:8. A write changes only the addressed byte. core_reg_data shows the register chosen by core_reg_sel.
- R4: A host write to either byte of general register 14 (offset 0x01C or 0x01D) makes rom_prefetch high for exactly the cycle after the write.
- R5: A host write to offset 0x01F sets the start bit (status bit 5), and core_go follows that bit from the next cycle.
- R6: A read of offset 0x031 returns status bits 15:8 and then clears status bit 15 (the interrupt flag, mirrored on host_irq). If core_irq_set is high in the same cycle, the flag stays set. Offset 0x030 reads status bits 7:0. Writes to 0x030 and 0x031 replace the low and high byte.
- R7: A write to 0x030 that takes status bit 5 from 1 to 0 clears the 16-bit cache base and pulses cache_flush in the next cycle. The same write with bit 5 already 0 does neither. core_cbr_we loads core_cbr_data into the cache base.
- R8: Offset 0x034 holds a 7-bit program bank (data bits 6:0) and reads back as {0, bank}. Every write to it pulses cache_flush in the next cycle.
- R9: Offsets 0x033 and 0x039 store only data bit 0, on bram_en and clk_sel. Offsets 0x037, 0x038 and 0x03A store full bytes on cfg_byte, screen_base and screen_mode. All five read as 0x00.
- R10: 0x036 reads rom_bank, 0x03B reads the VERSION parameter, 0x03C reads ram_bank, and 0x03E/0x03F read the cache base low and high byte. Host writes to these offsets change nothing. Unmapped reads return 0x00, and host_rdata is 0x00 when no read strobe is present.
- R11: cache_flush and rom_prefetch are single-cycle pulses that appear only after a write strobe. An address held without a strobe changes no state.
- R12: After a synchronous active-low reset, every register and output reads 0, except the rom_bank, ram_bank and VERSION readbacks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | HOST_AW | Host byte address; only bits 9:0 decoded |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rdata | output | 8 | Read data, valid while host_rd is high |
| cache_rd | output | 1 | Cache window read request |
| cache_wr | output | 1 | Cache window write request |
| cache_idx | output | 9 | Byte index within the cache window |
| cache_wdata | output | 8 | Write data to the cache |
| cache_rdata | input | 8 | Read data from the cache |
| cache_flush | output | 1 | One-cycle cache flush request |
| rom_prefetch | output | 1 | One-cycle ROM-buffer prefetch request |
| core_go | output | 1 | Core run enable (status bit 5) |
| host_irq | output | 1 | Interrupt to host (status bit 15) |
| core_irq_set | input | 1 | Core raises the interrupt flag |
| core_cbr_we | input | 1 | Core loads the cache base |
| core_cbr_data | input | 16 | Cache base value from the core |
| rom_bank | input | 8 | ROM bank value for readback |
| ram_bank | input | 8 | RAM bank value for readback |
| core_reg_sel | input | 4 | General register selected for the core |
| core_reg_data | output | 16 | Selected general register contents |
| cache_base | output | 16 | Cache base register |
| prog_bank | output | 7 | Program bank register |
| bram_en | output | 1 | Backup RAM enable |
| clk_sel | output | 1 | Clock select |
| cfg_byte | output | 8 | Configuration byte |
| screen_base | output | 8 | Screen base byte |
| screen_mode | output | 8 | Screen mode byte |

## Verification
The bench sets HOST_AW to 24 and drives random upper address bits on every access, so the rule that bits above 9 are ignored is tested on each transaction. It sets VERSION to 0x5A rather than the default, so a read of the version offset cannot be mistaken for the zero that an unmapped or reset read would return. The random mix aims at the general registers, the control block, the cache window and unmapped gaps. Directed cases cover the race between an interrupt read and an interrupt set, the stop transition, and held addresses with no strobe.

// File: rtl/cpx_pkg.sv
// Shared offsets, bit positions and region type for the host register block.
// Assumes a 10-bit local offset space; the host bus may be wider.
package cpx_pkg;
    localparam int OFF_W      = 10;
    localparam int STAT_GO    = 5;
    localparam int STAT_IRQ   = 15;
    localparam int PREF_REG   = 14;
    // Control block slot numbers (offset 0x030 + slot).
    localparam logic [3:0] SL_STAT_LO = 4'h0;
    localparam logic [3:0] SL_STAT_HI = 4'h1;
    localparam logic [3:0] SL_BRAM    = 4'h3;
    localparam logic [3:0] SL_PBANK   = 4'h4;
    localparam logic [3:0] SL_ROMB    = 4'h6;
    localparam logic [3:0] SL_CFG     = 4'h7;
    localparam logic [3:0] SL_SBASE   = 4'h8;
    localparam logic [3:0] SL_CLK     = 4'h9;
    localparam logic [3:0] SL_SMODE   = 4'hA;
    localparam logic [3:0] SL_VER     = 4'hB;
    localparam logic [3:0] SL_RAMB    = 4'hC;
    localparam logic [3:0] SL_CB_LO   = 4'hE;
    localparam logic [3:0] SL_CB_HI   = 4'hF;

    typedef enum logic [1:0] {
        RG_NONE  = 2'd0,
        RG_GPR   = 2'd1,
        RG_CTRL  = 2'd2,
        RG_CACHE = 2'd3
    } region_t;
endpackage

// File: rtl/cpx_host_decode.sv
// Region decoder: classifies a 10-bit local offset.
// Assumes offsets outside the three regions are unmapped.
module cpx_host_decode
    import cpx_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    output region_t          region
);
    // Pick the region from the upper offset bits.
    always_comb begin
        if (off[9:5] == 5'b0)
            region = RG_GPR;
        else if (off[9:4] == 6'h03)
            region = RG_CTRL;
        else if (off[9:8] == 2'b01 || off[9:8] == 2'b10)
            region = RG_CACHE;
        else
            region = RG_NONE;
    end
endmodule

// File: rtl/cpx_gpr_file.sv
// General register file: NREG registers of 2*8 bits, written one byte at a
// time by the host, read by byte for the host and by word for the core.
// Assumes at most one write per cycle.
module cpx_gpr_file #(
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic          hi,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic [IW-1:0] core_sel,
    output logic [15:0]   core_data
);
    logic [15:0] regs [NREG];

    // One register per generate slot, each byte written on its own.
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (we && idx == IW'(i)) begin
                if (hi) regs[i][15:8] <= wdata;
                else    regs[i][7:0]  <= wdata;
            end
        end

        assert_keep_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (we && idx == IW'(i) && !hi) |=> $stable(regs[i][15:8]));
        assert_keep_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (we && idx == IW'(i) && hi) |=> $stable(regs[i][7:0]));
    end

    // Byte readback for the host.
    assign rdata     = hi ? regs[idx][15:8] : regs[idx][7:0];
    // Word readback for the core.
    assign core_data = regs[core_sel];
endmodule

// File: rtl/cpx_ctrl_regs.sv
// Control block: status word, bank and configuration registers, cache base
// and the flush pulse. Assumes we/re are already qualified for the control
// region and that the host never strobes both in one cycle.
module cpx_ctrl_regs
    import cpx_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h04
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic        re,
    input  logic [3:0]  slot,
    input  logic [7:0]  wdata,
    input  logic        go_set,
    input  logic        core_irq_set,
    input  logic        core_cbr_we,
    input  logic [15:0] core_cbr_data,
    input  logic [7:0]  rom_bank,
    input  logic [7:0]  ram_bank,
    output logic [7:0]  rdata,
    output logic        go,
    output logic        irq,
    output logic        flush,
    output logic [15:0] cache_base,
    output logic [6:0]  prog_bank,
    output logic        bram_en,
    output logic        clk_sel,
    output logic [7:0]  cfg_byte,
    output logic [7:0]  screen_base,
    output logic [7:0]  screen_mode
);
    logic [15:0] stat, stat_n;
    logic        stop;

    // A host write of the low status byte that drops the start bit.
    assign stop = we && slot == SL_STAT_LO && stat[STAT_GO] && !wdata[STAT_GO];

    // Next status word; a core interrupt set wins over a read clear.
    always_comb begin
        stat_n = stat;
        if (go_set)                      stat_n[STAT_GO]  = 1'b1;
        if (we && slot == SL_STAT_LO)    stat_n[7:0]      = wdata;
        if (we && slot == SL_STAT_HI)    stat_n[15:8]     = wdata;
        if (re && slot == SL_STAT_HI)    stat_n[STAT_IRQ] = 1'b0;
        if (core_irq_set)                stat_n[STAT_IRQ] = 1'b1;
    end

    // Status word register.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= stat_n;
    end

    // Cache base: cleared by a stop, otherwise loaded by the core.
    always_ff @(posedge clk) begin
        if (!rst_n)           cache_base <= '0;
        else if (stop)        cache_base <= '0;
        else if (core_cbr_we) cache_base <= core_cbr_data;
    end

    // Flush pulse after a stop or a program bank write.
    always_ff @(posedge clk) begin
        if (!rst_n) flush <= 1'b0;
        else        flush <= stop || (we && slot == SL_PBANK);
    end

    // Host-writable configuration and bank registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_bank   <= '0;
            bram_en     <= 1'b0;
            clk_sel     <= 1'b0;
            cfg_byte    <= '0;
            screen_base <= '0;
            screen_mode <= '0;
        end else if (we) begin
            case (slot)
                SL_PBANK: prog_bank   <= wdata[6:0];
                SL_BRAM:  bram_en     <= wdata[0];
                SL_CLK:   clk_sel     <= wdata[0];
                SL_CFG:   cfg_byte    <= wdata;
                SL_SBASE: screen_base <= wdata;
                SL_SMODE: screen_mode <= wdata;
                default: ;
            endcase
        end
    end

    // Readback mux; write-only slots read as zero.
    always_comb begin
        case (slot)
            SL_STAT_LO: rdata = stat[7:0];
            SL_STAT_HI: rdata = stat[15:8];
            SL_PBANK:   rdata = {1'b0, prog_bank};
            SL_ROMB:    rdata = rom_bank;
            SL_VER:     rdata = VERSION;
            SL_RAMB:    rdata = ram_bank;
            SL_CB_LO:   rdata = cache_base[7:0];
            SL_CB_HI:   rdata = cache_base[15:8];
            default:    rdata = 8'h00;
        endcase
    end

    assign go  = stat[STAT_GO];
    assign irq = stat[STAT_IRQ];

    assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (re && slot == SL_STAT_HI && !core_irq_set) |=> !irq);
    assert_irq_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        core_irq_set |=> irq);
    assert_go_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        go_set |=> go);
    assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (cache_base == 16'h0 && flush && !go));
    assert_pbank_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && slot == SL_PBANK) |=> flush);
endmodule

// File: rtl/cpx_host_regs.sv
// Host register interface top: decodes the low ten host address bits,
// routes accesses to the general registers, the control block or the cache
// window, and produces the prefetch pulse. Assumes one-cycle strobes.
module cpx_host_regs
    import cpx_pkg::*;
#(
    parameter int         HOST_AW = 24,
    parameter logic [7:0] VERSION = 8'h04,
    localparam int        NREG    = 16,
    localparam int        RIW     = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [7:0]         host_wdata,
    input  logic               host_rd,
    input  logic               host_wr,
    output logic [7:0]         host_rdata,
    output logic               cache_rd,
    output logic               cache_wr,
    output logic [8:0]         cache_idx,
    output logic [7:0]         cache_wdata,
    input  logic [7:0]         cache_rdata,
    output logic               cache_flush,
    output logic               rom_prefetch,
    output logic               core_go,
    output logic               host_irq,
    input  logic               core_irq_set,
    input  logic               core_cbr_we,
    input  logic [15:0]        core_cbr_data,
    input  logic [7:0]         rom_bank,
    input  logic [7:0]         ram_bank,
    input  logic [RIW-1:0]     core_reg_sel,
    output logic [15:0]        core_reg_data,
    output logic [15:0]        cache_base,
    output logic [6:0]         prog_bank,
    output logic               bram_en,
    output logic               clk_sel,
    output logic [7:0]         cfg_byte,
    output logic [7:0]         screen_base,
    output logic [7:0]         screen_mode
);
    logic [OFF_W-1:0] off;
    logic             unused_hi_addr;
    region_t          region;
    logic [7:0]       gpr_rdata, ctrl_rdata;
    logic             gpr_we, ctrl_we, ctrl_re, go_set;

    assign off            = host_addr[OFF_W-1:0];
    assign unused_hi_addr = ^host_addr[HOST_AW-1:OFF_W];

    cpx_host_decode u_dec (
        .off    (off),
        .region (region)
    );

    assign gpr_we  = host_wr && region == RG_GPR;
    assign ctrl_we = host_wr && region == RG_CTRL;
    assign ctrl_re = host_rd && region == RG_CTRL;
    assign go_set  = gpr_we && off[4:0] == 5'h1F;

    cpx_gpr_file #(.NREG(NREG)) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (gpr_we),
        .idx       (off[RIW:1]),
        .hi        (off[0]),
        .wdata     (host_wdata),
        .rdata     (gpr_rdata),
        .core_sel  (core_reg_sel),
        .core_data (core_reg_data)
    );

    cpx_ctrl_regs #(.VERSION(VERSION)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .we            (ctrl_we),
        .re            (ctrl_re),
        .slot          (off[3:0]),
        .wdata         (host_wdata),
        .go_set        (go_set),
        .core_irq_set  (core_irq_set),
        .core_cbr_we   (core_cbr_we),
        .core_cbr_data (core_cbr_data),
        .rom_bank      (rom_bank),
        .ram_bank      (ram_bank),
        .rdata         (ctrl_rdata),
        .go            (core_go),
        .irq           (host_irq),
        .flush         (cache_flush),
        .cache_base    (cache_base),
        .prog_bank     (prog_bank),
        .bram_en       (bram_en),
        .clk_sel       (clk_sel),
        .cfg_byte      (cfg_byte),
        .screen_base   (screen_base),
        .screen_mode   (screen_mode)
    );

    // Cache window: offset - 0x100 equals {offset[9], offset[7:0]} in range.
    assign cache_rd    = host_rd && region == RG_CACHE;
    assign cache_wr    = host_wr && region == RG_CACHE;
    assign cache_idx   = {off[9], off[7:0]};
    assign cache_wdata = host_wdata;

    // Prefetch pulse after any byte write to the prefetch register.
    always_ff @(posedge clk) begin
        if (!rst_n) rom_prefetch <= 1'b0;
        else        rom_prefetch <= gpr_we && off[RIW:1] == RIW'(PREF_REG);
    end

    // Host read data mux, zero without a read strobe.
    always_comb begin
        if (!host_rd)
            host_rdata = 8'h00;
        else begin
            case (region)
                RG_GPR:   host_rdata = gpr_rdata;
                RG_CTRL:  host_rdata = ctrl_rdata;
                RG_CACHE: host_rdata = cache_rdata;
                default:  host_rdata = 8'h00;
            endcase
        end
    end

    assert_prefetch_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rom_prefetch |-> $past(host_wr) && $past(host_addr[OFF_W-1:1]) == 9'h00E);
    assert_pulse_needs_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_flush || rom_prefetch) |-> $past(host_wr));
    assert_cache_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_rd || cache_wr) |-> (off >= 10'h100 && off <= 10'h2FF));
endmodule

// File: tb/cpx_host_regs_test.sv
`timescale 1ns/1ps
module cpx_host_regs_test;
    localparam int         AW  = 24;
    localparam logic [7:0] VER = 8'h5A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic          host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0]    host_rdata;
    logic          cache_rd, cache_wr;
    logic [8:0]    cache_idx;
    logic [7:0]    cache_wdata;
    logic [7:0]    cache_rdata = '0;
    logic          cache_flush, rom_prefetch, core_go, host_irq;
    logic          core_irq_set = 1'b0, core_cbr_we = 1'b0;
    logic [15:0]   core_cbr_data = '0;
    logic [7:0]    rom_bank = 8'hC3, ram_bank = 8'h3C;
    logic [3:0]    core_reg_sel = '0;
    logic [15:0]   core_reg_data, cache_base;
    logic [6:0]    prog_bank;
    logic          bram_en, clk_sel;
    logic [7:0]    cfg_byte, screen_base, screen_mode;

    int n_chk = 0, n_bad = 0;

    // Reference model state.
    logic [15:0] m_gpr [16];
    logic [15:0] m_stat, m_cb;
    logic [6:0]  m_pb;
    logic        m_bram, m_clk;
    logic [7:0]  m_cfg, m_sb, m_sm;

    always #5 clk = ~clk;

    cpx_host_regs #(.HOST_AW(AW), .VERSION(VER)) uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
        .cache_rd(cache_rd), .cache_wr(cache_wr), .cache_idx(cache_idx),
        .cache_wdata(cache_wdata), .cache_rdata(cache_rdata),
        .cache_flush(cache_flush), .rom_prefetch(rom_prefetch), .core_go(core_go),
        .host_irq(host_irq), .core_irq_set(core_irq_set), .core_cbr_we(core_cbr_we),
        .core_cbr_data(core_cbr_data), .rom_bank(rom_bank), .ram_bank(ram_bank),
        .core_reg_sel(core_reg_sel), .core_reg_data(core_reg_data),
        .cache_base(cache_base), .prog_bank(prog_bank), .bram_en(bram_en),
        .clk_sel(clk_sel), .cfg_byte(cfg_byte), .screen_base(screen_base),
        .screen_mode(screen_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected host read byte for an offset, from model state (R3, R6, R8-R10).
    function automatic logic [7:0] exp_rd(input logic [9:0] o, input logic [7:0] crd);
        if (o[9:5] == 0) return o[0] ? m_gpr[o[4:1]][15:8] : m_gpr[o[4:1]][7:0];
        if (o >= 10'h100 && o <= 10'h2FF) return crd;
        case (o)
            10'h030: return m_stat[7:0];
            10'h031: return m_stat[15:8];
            10'h034: return {1'b0, m_pb};
            10'h036: return rom_bank;
            10'h03B: return VER;
            10'h03C: return ram_bank;
            10'h03E: return m_cb[7:0];
            10'h03F: return m_cb[15:8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk_state(input string tag);
        chk({tag, " R5 core_go"}, core_go, m_stat[5]);
        chk({tag, " R6 host_irq"}, host_irq, m_stat[15]);
        chk({tag, " R7 cache_base"}, cache_base, m_cb);
        chk({tag, " R8 prog_bank"}, prog_bank, m_pb);
        chk({tag, " R9 cfg"}, {bram_en, clk_sel, cfg_byte, screen_base, screen_mode},
            {m_bram, m_clk, m_cfg, m_sb, m_sm});
        chk({tag, " R3 core_reg_data"}, core_reg_data, m_gpr[core_reg_sel]);
    endtask

    // One host access (kind: 0 none, 1 read, 2 write), optional core irq set.
    task automatic access(input int kind, input logic [AW-1:0] a, input logic [7:0] d,
                          input logic irqset);
        logic [9:0] o;
        logic       win, exp_fl, exp_pf;
        logic [7:0] crd;
        o = a[9:0];
        crd = 8'($urandom);
        win = (o >= 10'h100 && o <= 10'h2FF);
        @(negedge clk);
        host_addr = a; host_wdata = d; cache_rdata = crd;
        host_rd = (kind == 1); host_wr = (kind == 2); core_irq_set = irqset;
        core_reg_sel = 4'($urandom);
        #1;
        chk("R10 rdata", host_rdata, (kind == 1) ? exp_rd(o, crd) : 8'h00);
        chk("R2 cache_rd", cache_rd, (kind == 1) && win);
        chk("R2 cache_wr", cache_wr, (kind == 2) && win);
        if (win) chk("R2 cache_idx/wdata", {cache_idx, cache_wdata}, {9'(o - 10'h100), d});
        exp_fl = (kind == 2) && ((o == 10'h030 && m_stat[5] && !d[5]) || o == 10'h034);
        exp_pf = (kind == 2) && o[9:5] == 0 && o[4:1] == 4'd14;
        // Model update for this edge.
        if (kind == 2) begin
            if (o[9:5] == 0) begin
                if (o[0]) m_gpr[o[4:1]][15:8] = d; else m_gpr[o[4:1]][7:0] = d;
                if (o[4:0] == 5'h1F) m_stat[5] = 1'b1;
            end
            case (o)
                10'h030: begin if (m_stat[5] && !d[5]) m_cb = '0; m_stat[7:0] = d; end
                10'h031: m_stat[15:8] = d;
                10'h033: m_bram = d[0];
                10'h034: m_pb = d[6:0];
                10'h037: m_cfg = d;
                10'h038: m_sb = d;
                10'h039: m_clk = d[0];
                10'h03A: m_sm = d;
                default: ;
            endcase
        end
        if (kind == 1 && o == 10'h031) m_stat[15] = 1'b0;
        if (irqset) m_stat[15] = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0; core_irq_set = 1'b0;
        chk("R7 R8 R11 cache_flush", cache_flush, exp_fl);
        chk("R4 R11 rom_prefetch", rom_prefetch, exp_pf);
        chk_state("after access");
    endtask

    task automatic core_cb_load(input logic [15:0] v);
        @(negedge clk);
        core_cbr_we = 1'b1; core_cbr_data = v;
        @(negedge clk);
        core_cbr_we = 1'b0; m_cb = v;
        chk("R7 core load", cache_base, v);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) m_gpr[i] = '0;
        m_stat = '0; m_cb = '0; m_pb = '0; m_bram = 0; m_clk = 0;
        m_cfg = '0; m_sb = '0; m_sm = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state.
        @(negedge clk);
        chk("R12 reset flush/prefetch", {cache_flush, rom_prefetch}, 2'b00);
        chk_state("R12 reset");
        access(1, 24'h00003B, 8'h00, 1'b0);
        access(1, 24'h000030, 8'h00, 1'b0);
        // R1: upper address bits ignored.
        access(2, 24'hABC005, 8'h77, 1'b0);
        access(1, 24'h123005, 8'h00, 1'b0);
        chk("R1 upper bits", m_gpr[2][15:8], 8'h77);
        // R6: interrupt raised, read clears; race keeps it set.
        access(0, 24'h000000, 8'h00, 1'b1);
        access(0, 24'h000031, 8'h00, 1'b0);   // R11: address held, no strobe
        chk("R11 irq kept without strobe", host_irq, 1'b1);
        access(1, 24'h000031, 8'h00, 1'b0);
        chk("R6 irq cleared", host_irq, 1'b0);
        access(0, 24'h000000, 8'h00, 1'b1);
        access(1, 24'h000031, 8'h00, 1'b1);
        chk("R6 set wins", host_irq, 1'b1);
        // R7: load base, start via 0x01F, stop via 0x030.
        core_cb_load(16'h1234);
        access(1, 24'h00003E, 8'h00, 1'b0);
        access(1, 24'h00003F, 8'h00, 1'b0);
        access(2, 24'h00001F, 8'h81, 1'b0);
        chk("R5 started", core_go, 1'b1);
        access(2, 24'h000030, 8'h00, 1'b0);
        chk("R7 stopped base", cache_base, 16'h0000);
        core_cb_load(16'hBEEF);
        access(2, 24'h000030, 8'h00, 1'b0);   // already stopped: no flush
        chk("R7 no flush when idle", cache_base, 16'hBEEF);
        // R10: read-only slots ignore writes.
        access(2, 24'h00003E, 8'h11, 1'b0);
        access(2, 24'h00003B, 8'h11, 1'b0);
        access(1, 24'h00003B, 8'h00, 1'b0);
        // Random mix.
        for (int n = 0; n < 1500; n++) begin
            logic [9:0] o;
            int         k;
            case ($urandom_range(0, 3))
                0: o = 10'($urandom_range(0, 31));
                1: o = 10'h030 + 10'($urandom_range(0, 15));
                2: o = 10'($urandom_range(10'h100, 10'h2FF));
                default: o = ($urandom_range(0, 1) == 0) ? 10'($urandom_range(10'h020, 10'h02F))
                                                         : 10'($urandom_range(10'h2F0, 10'h3FF));
            endcase
            k = $urandom_range(0, 2);
            access(k, {14'($urandom), o}, 8'($urandom), ($urandom_range(0, 15) == 0));
            if ($urandom_range(0, 40) == 0) core_cb_load(16'($urandom));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule